// File: doc/BRIEF.md
# Floating-Point Escape Opcode Decoder

This block classifies one floating-point coprocessor instruction from its escape index (0 to 7, the low three bits of the escape opcode), its ModR/M byte and a flag that tells whether the operand lives in memory or on the register stack. It produces a compact control word for the rest of the floating-point unit. The control word holds an operation code, two stack selectors relative to the current stack top, the memory operand format, a push request, a pop count and an unhandled flag.

The escape map is irregular, and the decoder takes care of all of it. The four memory formats share one arithmetic tree. The reversed register forms swap operand order and also swap subtract/reverse-subtract and divide/reverse-divide. Every register form of escape 6 carries an implicit pop. A handful of instructions exist at a single encoding only. The block does no address generation, arithmetic or memory transfer.

The decoded word is captured on a valid strobe. An encoding that is unhandled or illegal comes out as an all-zero word with the unhandled flag set, so it can never push, pop or start an operation.

Top module: `fpesc_decoder`

## Requirements
- R1: The group field is modrm[5:3] and the sub field is modrm[2:0]. The decoded word appears one clock after a cycle with `in_valid` high, with `out_valid` high for that one cycle only. While `in_valid` is low, the word holds its last value. Synchronous reset clears every output to zero.
- R2: Memory forms of escapes 0, 2, 4 and 6 use format codes 1 (32-bit real), 2 (32-bit integer), 3 (64-bit real) and 4 (16-bit integer). Groups 0..7 give operation codes 0x01 add, 0x02 mul, 0x03 compare, 0x03 compare with one pop, 0x04 sub, 0x05 reverse-sub, 0x06 div and 0x07 reverse-div. Both selectors are 0 and there is no push.
- R3: In register form, escape 0 uses the same group-to-operation mapping as R2. The destination is 0, the source is the sub field, the format is 0, and only group 3 pops (one).
- R4: In register form, escape 4 writes to ST(sub): destination = sub, source = 0. Groups 4, 5, 6 and 7 give 0x05, 0x04, 0x07 and 0x06. Groups 2 and 3 compare with destination 0 and source = sub, and group 3 pops once.
- R5: Every register form of escape 6 pops once and otherwise maps like R4. The exception is group 3, which is valid only with sub 1: it decodes as compare 0x03 with destination 0, source 1 and pop count 2. Any other sub in group 3 is unhandled. The pop count never exceeds 2.
- R6: Escape 2, register form, group 5 with sub 1 decodes as unordered compare 0x08 with destination 0, source 1 and pop count 2. Every other escape 2 register encoding is unhandled.
- R7: Escape 1, register form, group 5 with sub 0..6 loads a constant with operation code 0x18 + sub and a push. Sub 7 is unhandled.
- R8: Escape 1, register form, groups 6 and 7 give operation codes 0x20 + sub and 0x28 + sub, with no push and no pop. Code 0x26 decrements the stack top and 0x27 increments it.
- R9: Escape 3, register form, group 4 gives 0x11 (clear exceptions) for sub 2, 0x12 (initialise) for sub 3, and 0x0C (no-op) for subs 4 and 5. Subs 0, 1, 6 and 7 and every other escape 3 register group are unhandled.
- R10: Escape 5, register form, group 0 gives 0x13 (free) with destination = sub. Escape 7, register form, group 4 with sub 0 gives 0x14 (status to accumulator) with format 0, and any other sub there is unhandled.
- R11: An unhandled encoding sets `unhandled`, and every other field of the word is zero: no push and no pop.
- R12: Loads give 0x09 with a push and no pop. They are escape 1 register group 0 (source = sub) and the memory forms escape 1 group 0 (format 1), escape 3 groups 0 (format 2) and 5 (format 5), escape 5 group 0 (format 3), and escape 7 groups 0 (format 4), 4 (format 7, decimal) and 5 (format 6, 64-bit integer). Memory stores give 0x0A with no push: group 2 does not pop, and group 3, escape 3 group 7 and escape 7 groups 6 and 7 pop once.
- R13: Register stores give 0x0A with destination = sub and source 0. The pop count is 1 for escape 1 group 3, escape 5 group 3 and escape 7 groups 2 and 3, and 0 for escape 5 group 2. Exchange 0x0B has destination 0 and source = sub, in escape 1, 5 and 7 group 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the instruction fields |
| esc_idx | input | 3 | Escape index 0..7 |
| modrm | input | 8 | ModR/M byte |
| mem_form | input | 1 | 1 = memory operand, 0 = register form |
| out_valid | output | 1 | Decoded word updated this cycle |
| op_code | output | 6 | Decoded operation code |
| dst_sel | output | 3 | Destination stack index relative to top |
| src_sel | output | 3 | Source stack index relative to top |
| mem_fmt | output | 4 | Memory operand format code, 0 for none |
| push | output | 1 | Stack push request |
| pop_cnt | output | 2 | Number of pops after the operation |
| unhandled | output | 1 | Encoding unhandled or illegal |

## Verification
The latency and hold properties assume that `in_valid` is low while reset is applied, and that every field is known whenever the strobe is high. The bench drives all inputs on the falling edge and raises the strobe for one cycle per instruction, so both conditions always hold. The properties that tie escape 6 register forms to a pop, and memory forms to a format, also take `mem_form` as already settled by the upstream mode decode. The bench never toggles it within a strobed cycle.

// File: rtl/fpesc_pkg.sv
package fpesc_pkg;
  localparam int ESC_W   = 3;
  localparam int FIELD_W = 3;
  localparam int MODRM_W = 8;
  localparam int OP_W    = 6;
  localparam int FMT_W   = 4;
  localparam int POP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = 6'h00, OP_ADD   = 6'h01, OP_MUL    = 6'h02, OP_COM    = 6'h03,
    OP_SUB    = 6'h04, OP_SUBR  = 6'h05, OP_DIV    = 6'h06, OP_DIVR   = 6'h07,
    OP_UCOM   = 6'h08, OP_LD    = 6'h09, OP_ST     = 6'h0A, OP_XCH    = 6'h0B,
    OP_NOP    = 6'h0C, OP_CHS   = 6'h0D, OP_ABS    = 6'h0E, OP_TST    = 6'h0F,
    OP_XAM    = 6'h10, OP_CLEX  = 6'h11, OP_INIT   = 6'h12, OP_FREE   = 6'h13,
    OP_STSW   = 6'h14, OP_LDENV = 6'h15, OP_STENV  = 6'h16, OP_LDCW   = 6'h17,
    OP_K_ONE  = 6'h18, OP_K_L2T = 6'h19, OP_K_L2E  = 6'h1A, OP_K_PI   = 6'h1B,
    OP_K_LG2  = 6'h1C, OP_K_LN2 = 6'h1D, OP_K_ZERO = 6'h1E,
    OP_EXP2M1 = 6'h20, OP_YLOG  = 6'h21, OP_TAN    = 6'h22, OP_ATAN   = 6'h23,
    OP_SPLIT  = 6'h24, OP_REMN  = 6'h25, OP_TOPDEC = 6'h26, OP_TOPINC = 6'h27,
    OP_REMT   = 6'h28, OP_YLOGP1= 6'h29, OP_SQRT   = 6'h2A, OP_SINCOS = 6'h2B,
    OP_ROUND  = 6'h2C, OP_SCALE = 6'h2D, OP_SIN    = 6'h2E, OP_COS    = 6'h2F,
    OP_STCW   = 6'h30, OP_RSTOR = 6'h31, OP_SAVE   = 6'h32
  } op_e;

  typedef enum logic [FMT_W-1:0] {
    MF_NONE = 4'd0, MF_F32 = 4'd1, MF_I32 = 4'd2, MF_F64 = 4'd3,
    MF_I16  = 4'd4, MF_F80 = 4'd5, MF_I64 = 4'd6, MF_BCD = 4'd7,
    MF_WORD = 4'd8, MF_ENV = 4'd9, MF_STATE = 4'd10
  } mfmt_e;

  typedef struct packed {
    op_e                op;
    logic [FIELD_W-1:0] dst;
    logic [FIELD_W-1:0] src;
    mfmt_e              fmt;
    logic               push;
    logic [POP_W-1:0]   pop;
    logic               bad;
  } dec_t;

  function automatic dec_t mk(op_e op, logic [FIELD_W-1:0] dst, logic [FIELD_W-1:0] src,
                              mfmt_e fmt, logic push, logic [POP_W-1:0] pop);
    dec_t d;
    d.op = op; d.dst = dst; d.src = src; d.fmt = fmt;
    d.push = push; d.pop = pop; d.bad = 1'b0;
    return d;
  endfunction

  function automatic dec_t bad_dec();
    dec_t d;
    d = '0;
    d.bad = 1'b1;
    return d;
  endfunction

  // Operation codes laid out as base + sub for the sequential register groups.
  function automatic op_e seq_op(logic [OP_W-1:0] base, logic [FIELD_W-1:0] sub);
    return op_e'(base + {{(OP_W-FIELD_W){1'b0}}, sub});
  endfunction
endpackage

// File: rtl/fpesc_arith_tree.sv
module fpesc_arith_tree
  import fpesc_pkg::*;
(
  input  logic [FIELD_W-1:0] grp,
  input  logic               reversed,
  output op_e                op,
  output logic               comp_pop
);
  always_comb begin
    unique case (grp)
      3'd0:       op = OP_ADD;
      3'd1:       op = OP_MUL;
      3'd2, 3'd3: op = OP_COM;
      3'd4:       op = reversed ? OP_SUBR : OP_SUB;
      3'd5:       op = reversed ? OP_SUB  : OP_SUBR;
      3'd6:       op = reversed ? OP_DIVR : OP_DIV;
      default:    op = reversed ? OP_DIV  : OP_DIVR;
    endcase
  end

  assign comp_pop = (grp == 3'd3);
endmodule

// File: rtl/fpesc_mem_decode.sv
module fpesc_mem_decode
  import fpesc_pkg::*;
(
  input  logic [ESC_W-1:0]   esc,
  input  logic [FIELD_W-1:0] grp,
  input  op_e                tree_op,
  input  logic               tree_pop,
  output dec_t               dec
);
  mfmt_e tree_fmt;

  always_comb begin
    unique case (esc[2:1])
      2'd0:    tree_fmt = MF_F32;
      2'd1:    tree_fmt = MF_I32;
      2'd2:    tree_fmt = MF_F64;
      default: tree_fmt = MF_I16;
    endcase
  end

  always_comb begin
    dec = bad_dec();
    if (!esc[0]) begin
      dec = mk(tree_op, 3'd0, 3'd0, tree_fmt, 1'b0, {1'b0, tree_pop});
    end else begin
      unique case (esc)
        3'd1: unique case (grp)
          3'd0: dec = mk(OP_LD,    3'd0, 3'd0, MF_F32,  1'b1, 2'd0);
          3'd2: dec = mk(OP_ST,    3'd0, 3'd0, MF_F32,  1'b0, 2'd0);
          3'd3: dec = mk(OP_ST,    3'd0, 3'd0, MF_F32,  1'b0, 2'd1);
          3'd4: dec = mk(OP_LDENV, 3'd0, 3'd0, MF_ENV,  1'b0, 2'd0);
          3'd5: dec = mk(OP_LDCW,  3'd0, 3'd0, MF_WORD, 1'b0, 2'd0);
          3'd6: dec = mk(OP_STENV, 3'd0, 3'd0, MF_ENV,  1'b0, 2'd0);
          3'd7: dec = mk(OP_STCW,  3'd0, 3'd0, MF_WORD, 1'b0, 2'd0);
          default: dec = bad_dec();
        endcase
        3'd3: unique case (grp)
          3'd0: dec = mk(OP_LD, 3'd0, 3'd0, MF_I32, 1'b1, 2'd0);
          3'd2: dec = mk(OP_ST, 3'd0, 3'd0, MF_I32, 1'b0, 2'd0);
          3'd3: dec = mk(OP_ST, 3'd0, 3'd0, MF_I32, 1'b0, 2'd1);
          3'd5: dec = mk(OP_LD, 3'd0, 3'd0, MF_F80, 1'b1, 2'd0);
          3'd7: dec = mk(OP_ST, 3'd0, 3'd0, MF_F80, 1'b0, 2'd1);
          default: dec = bad_dec();
        endcase
        3'd5: unique case (grp)
          3'd0: dec = mk(OP_LD,    3'd0, 3'd0, MF_F64,   1'b1, 2'd0);
          3'd2: dec = mk(OP_ST,    3'd0, 3'd0, MF_F64,   1'b0, 2'd0);
          3'd3: dec = mk(OP_ST,    3'd0, 3'd0, MF_F64,   1'b0, 2'd1);
          3'd4: dec = mk(OP_RSTOR, 3'd0, 3'd0, MF_STATE, 1'b0, 2'd0);
          3'd6: dec = mk(OP_SAVE,  3'd0, 3'd0, MF_STATE, 1'b0, 2'd0);
          3'd7: dec = mk(OP_STSW,  3'd0, 3'd0, MF_WORD,  1'b0, 2'd0);
          default: dec = bad_dec();
        endcase
        default: unique case (grp)
          3'd0: dec = mk(OP_LD, 3'd0, 3'd0, MF_I16, 1'b1, 2'd0);
          3'd2: dec = mk(OP_ST, 3'd0, 3'd0, MF_I16, 1'b0, 2'd0);
          3'd3: dec = mk(OP_ST, 3'd0, 3'd0, MF_I16, 1'b0, 2'd1);
          3'd4: dec = mk(OP_LD, 3'd0, 3'd0, MF_BCD, 1'b1, 2'd0);
          3'd5: dec = mk(OP_LD, 3'd0, 3'd0, MF_I64, 1'b1, 2'd0);
          3'd6: dec = mk(OP_ST, 3'd0, 3'd0, MF_BCD, 1'b0, 2'd1);
          3'd7: dec = mk(OP_ST, 3'd0, 3'd0, MF_I64, 1'b0, 2'd1);
          default: dec = bad_dec();
        endcase
      endcase
    end
  end
endmodule

// File: rtl/fpesc_reg_decode.sv
module fpesc_reg_decode
  import fpesc_pkg::*;
(
  input  logic [ESC_W-1:0]   esc,
  input  logic [FIELD_W-1:0] grp,
  input  logic [FIELD_W-1:0] sub,
  input  op_e                tree_op,
  input  logic               tree_pop,
  output dec_t               dec
);
  logic is_cmp;
  assign is_cmp = (grp == 3'd2) || (grp == 3'd3);

  always_comb begin
    dec = bad_dec();
    unique case (esc)
      // ST := ST op ST(i)
      3'd0: dec = mk(tree_op, 3'd0, sub, MF_NONE, 1'b0, {1'b0, tree_pop});
      3'd1: unique case (grp)
        3'd0: dec = mk(OP_LD,  3'd0, sub,  MF_NONE, 1'b1, 2'd0);
        3'd1: dec = mk(OP_XCH, 3'd0, sub,  MF_NONE, 1'b0, 2'd0);
        3'd2: dec = mk(OP_NOP, 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
        3'd3: dec = mk(OP_ST,  sub,  3'd0, MF_NONE, 1'b0, 2'd1);
        3'd4: unique case (sub)
          3'd0: dec = mk(OP_CHS, 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
          3'd1: dec = mk(OP_ABS, 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
          3'd4: dec = mk(OP_TST, 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
          3'd5: dec = mk(OP_XAM, 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
          default: dec = bad_dec();
        endcase
        3'd5: dec = (sub == 3'd7) ? bad_dec()
                  : mk(seq_op(6'h18, sub), 3'd0, 3'd0, MF_NONE, 1'b1, 2'd0);
        3'd6: dec = mk(seq_op(6'h20, sub), 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
        default: dec = mk(seq_op(6'h28, sub), 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
      endcase
      3'd2: dec = (grp == 3'd5 && sub == 3'd1)
                ? mk(OP_UCOM, 3'd0, 3'd1, MF_NONE, 1'b0, 2'd2) : bad_dec();
      3'd3: begin
        if (grp == 3'd4) begin
          unique case (sub)
            3'd2:       dec = mk(OP_CLEX, 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
            3'd3:       dec = mk(OP_INIT, 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
            3'd4, 3'd5: dec = mk(OP_NOP,  3'd0, 3'd0, MF_NONE, 1'b0, 2'd0);
            default:    dec = bad_dec();
          endcase
        end
      end
      // ST(i) := ST(i) op ST, with the reversed subtract/divide mapping
      3'd4: dec = is_cmp ? mk(tree_op, 3'd0, sub, MF_NONE, 1'b0, {1'b0, tree_pop})
                         : mk(tree_op, sub, 3'd0, MF_NONE, 1'b0, 2'd0);
      3'd5: unique case (grp)
        3'd0: dec = mk(OP_FREE, sub,  3'd0, MF_NONE, 1'b0, 2'd0);
        3'd1: dec = mk(OP_XCH,  3'd0, sub,  MF_NONE, 1'b0, 2'd0);
        3'd2: dec = mk(OP_ST,   sub,  3'd0, MF_NONE, 1'b0, 2'd0);
        3'd3: dec = mk(OP_ST,   sub,  3'd0, MF_NONE, 1'b0, 2'd1);
        3'd4: dec = mk(OP_UCOM, 3'd0, sub,  MF_NONE, 1'b0, 2'd0);
        3'd5: dec = mk(OP_UCOM, 3'd0, sub,  MF_NONE, 1'b0, 2'd1);
        default: dec = bad_dec();
      endcase
      // every register form pops once; the double compare pops twice
      3'd6: begin
        if (grp == 3'd3)
          dec = (sub == 3'd1) ? mk(OP_COM, 3'd0, 3'd1, MF_NONE, 1'b0, 2'd2) : bad_dec();
        else if (grp == 3'd2)
          dec = mk(OP_COM, 3'd0, sub, MF_NONE, 1'b0, 2'd1);
        else
          dec = mk(tree_op, sub, 3'd0, MF_NONE, 1'b0, 2'd1);
      end
      default: unique case (grp)
        3'd1:       dec = mk(OP_XCH, 3'd0, sub,  MF_NONE, 1'b0, 2'd0);
        3'd2, 3'd3: dec = mk(OP_ST,  sub,  3'd0, MF_NONE, 1'b0, 2'd1);
        3'd4:       dec = (sub == 3'd0) ? mk(OP_STSW, 3'd0, 3'd0, MF_NONE, 1'b0, 2'd0)
                                        : bad_dec();
        default:    dec = bad_dec();
      endcase
    endcase
  end
endmodule

// File: rtl/fpesc_decoder.sv
module fpesc_decoder
  import fpesc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [ESC_W-1:0]   esc_idx,
  input  logic [MODRM_W-1:0] modrm,
  input  logic               mem_form,
  output logic               out_valid,
  output logic [OP_W-1:0]    op_code,
  output logic [FIELD_W-1:0] dst_sel,
  output logic [FIELD_W-1:0] src_sel,
  output logic [FMT_W-1:0]   mem_fmt,
  output logic               push,
  output logic [POP_W-1:0]   pop_cnt,
  output logic               unhandled
);
  logic [FIELD_W-1:0] grp, sub;
  logic               unused_mod;
  logic               reversed, tree_pop;
  op_e                tree_op;
  dec_t               mem_d, reg_d, raw_d, fin_d, out_d;
  logic               v_q;

  assign grp        = modrm[5:3];
  assign sub        = modrm[2:0];
  assign unused_mod = ^modrm[7:6];
  assign reversed   = !mem_form && (esc_idx == 3'd4 || esc_idx == 3'd6);

  fpesc_arith_tree u_tree (
    .grp(grp), .reversed(reversed), .op(tree_op), .comp_pop(tree_pop)
  );

  fpesc_mem_decode u_mem (
    .esc(esc_idx), .grp(grp), .tree_op(tree_op), .tree_pop(tree_pop), .dec(mem_d)
  );

  fpesc_reg_decode u_reg (
    .esc(esc_idx), .grp(grp), .sub(sub), .tree_op(tree_op), .tree_pop(tree_pop), .dec(reg_d)
  );

  assign raw_d = mem_form ? mem_d : reg_d;
  // an unhandled encoding must not touch the stack
  assign fin_d = raw_d.bad ? bad_dec() : raw_d;

  generate
    if (REG_OUT) begin : g_reg
      dec_t q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q   <= '0;
          v_q <= 1'b0;
        end else begin
          v_q <= in_valid;
          if (in_valid) q <= fin_d;
        end
      end
      assign out_d = q;
    end else begin : g_comb
      assign out_d = fin_d;
      assign v_q   = in_valid;
    end
  endgenerate

  assign out_valid = v_q;
  assign op_code   = out_d.op;
  assign dst_sel   = out_d.dst;
  assign src_sel   = out_d.src;
  assign mem_fmt   = out_d.fmt;
  assign push      = out_d.push;
  assign pop_cnt   = out_d.pop;
  assign unhandled = out_d.bad;
endmodule

// File: rtl/fpesc_decoder_chk.sv
module fpesc_decoder_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [2:0] esc_idx,
  input logic       mem_form,
  input logic       out_valid,
  input logic [5:0] op_code,
  input logic [2:0] dst_sel,
  input logic [2:0] src_sel,
  input logic [3:0] mem_fmt,
  input logic       push,
  input logic [1:0] pop_cnt,
  input logic       unhandled
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_BAD_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
    unhandled |-> (!push && pop_cnt == 2'd0 && op_code == 6'd0)); // R11
  AST_POP_BOUND: assert property (@(posedge clk) disable iff (rst)
    pop_cnt != 2'd3); // R5
  AST_PUSH_NO_POP: assert property (@(posedge clk) disable iff (rst)
    push |-> pop_cnt == 2'd0); // R12

  generate
    if (REG_OUT) begin : g_seq
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(in_valid))); // R1
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(in_valid)) |->
          ($stable(op_code) && $stable(dst_sel) && $stable(src_sel) &&
           $stable(mem_fmt) && $stable(push) && $stable(pop_cnt) && $stable(unhandled))); // R1
      AST_ESC6_REG_POPS: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(in_valid && !mem_form && esc_idx == 3'd6) && !unhandled)
          |-> pop_cnt != 2'd0); // R5
      AST_MEM_HAS_FMT: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(in_valid && mem_form) && !unhandled) |-> mem_fmt != 4'd0); // R2
    end
  endgenerate
endmodule

bind fpesc_decoder fpesc_decoder_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .esc_idx(esc_idx), .mem_form(mem_form),
  .out_valid(out_valid), .op_code(op_code), .dst_sel(dst_sel), .src_sel(src_sel),
  .mem_fmt(mem_fmt), .push(push), .pop_cnt(pop_cnt), .unhandled(unhandled)
);

// File: tb/tb_fpesc_decoder.sv
module tb_fpesc_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] esc_idx = 3'd0;
  logic [7:0] modrm = 8'd0;
  logic       mem_form = 1'b0;
  logic       out_valid, push, unhandled;
  logic [5:0] op_code;
  logic [2:0] dst_sel, src_sel;
  logic [3:0] mem_fmt;
  logic [1:0] pop_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fpesc_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .esc_idx(esc_idx), .modrm(modrm),
    .mem_form(mem_form), .out_valid(out_valid), .op_code(op_code), .dst_sel(dst_sel),
    .src_sel(src_sel), .mem_fmt(mem_fmt), .push(push), .pop_cnt(pop_cnt),
    .unhandled(unhandled)
  );

  function automatic logic [7:0] rm(input logic mem, input logic [2:0] g, input logic [2:0] s);
    return {mem ? 2'b00 : 2'b11, g, s};
  endfunction

  task automatic drive(input logic [2:0] e, input logic [2:0] g, input logic [2:0] s,
                       input logic mem);
    @(negedge clk);
    esc_idx = e; modrm = rm(mem, g, s); mem_form = mem; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_word(input string tag, input logic ev, input logic [5:0] eop,
                            input logic [2:0] ed, input logic [2:0] es, input logic [3:0] ef,
                            input logic ep, input logic [1:0] epop, input logic eb);
    logic [20:0] got, exp;
    got = {out_valid, op_code, dst_sel, src_sel, mem_fmt, push, pop_cnt, unhandled};
    exp = {ev, eop, ed, es, ef, ep, epop, eb};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got v=%0b op=%h d=%0d s=%0d f=%0d push=%0b pop=%0d bad=%0b exp v=%0b op=%h d=%0d s=%0d f=%0d push=%0b pop=%0d bad=%0b",
               tag, got[20], got[19:14], got[13:11], got[10:8], got[7:4], got[3], got[2:1], got[0],
               ev, eop, ed, es, ef, ep, epop, eb);
    end
  endtask

  task automatic dec_chk(input string tag, input logic [2:0] e, input logic [2:0] g,
                         input logic [2:0] s, input logic mem, input logic [5:0] eop,
                         input logic [2:0] ed, input logic [2:0] es, input logic [3:0] ef,
                         input logic ep, input logic [1:0] epop);
    drive(e, g, s, mem);
    check_word(tag, 1'b1, eop, ed, es, ef, ep, epop, 1'b0);
  endtask

  task automatic bad_chk(input string tag, input logic [2:0] e, input logic [2:0] g,
                         input logic [2:0] s, input logic mem);
    drive(e, g, s, mem);
    check_word(tag, 1'b1, 6'h00, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0, 1'b1);
  endtask

  function automatic logic [5:0] fwd_op(input logic [2:0] g);
    case (g)
      3'd0: return 6'h01; 3'd1: return 6'h02; 3'd2: return 6'h03; 3'd3: return 6'h03;
      3'd4: return 6'h04; 3'd5: return 6'h05; 3'd6: return 6'h06; default: return 6'h07;
    endcase
  endfunction

  function automatic logic [5:0] rev_op(input logic [2:0] g);
    case (g)
      3'd4: return 6'h05; 3'd5: return 6'h04; 3'd6: return 6'h07; 3'd7: return 6'h06;
      default: return fwd_op(g);
    endcase
  endfunction

  task automatic t_reset();
    check_word("R1 reset", 1'b0, 6'h00, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_mem_tree();
    logic [2:0] escs [4] = '{3'd0, 3'd2, 3'd4, 3'd6};
    for (int i = 0; i < 4; i++)
      for (int g = 0; g < 8; g++)
        dec_chk("R2 mem tree", escs[i], 3'(g), 3'(7 - g), 1'b1, fwd_op(3'(g)), 3'd0, 3'd0,
                4'(i + 1), 1'b0, (g == 3) ? 2'd1 : 2'd0);
  endtask

  task automatic t_esc0_reg();
    for (int g = 0; g < 8; g++)
      dec_chk("R3 esc0 reg", 3'd0, 3'(g), 3'(g ^ 5), 1'b0, fwd_op(3'(g)), 3'd0, 3'(g ^ 5),
              4'd0, 1'b0, (g == 3) ? 2'd1 : 2'd0);
  endtask

  task automatic t_esc4_reg();
    for (int g = 0; g < 8; g++) begin
      if (g == 2 || g == 3)
        dec_chk("R4 esc4 cmp", 3'd4, 3'(g), 3'd6, 1'b0, 6'h03, 3'd0, 3'd6, 4'd0, 1'b0,
                (g == 3) ? 2'd1 : 2'd0);
      else
        dec_chk("R4 esc4 rev", 3'd4, 3'(g), 3'd3, 1'b0, rev_op(3'(g)), 3'd3, 3'd0, 4'd0,
                1'b0, 2'd0);
    end
  endtask

  task automatic t_esc6_reg();
    for (int g = 0; g < 8; g++) begin
      if (g == 2)
        dec_chk("R5 esc6 cmp", 3'd6, 3'd2, 3'd4, 1'b0, 6'h03, 3'd0, 3'd4, 4'd0, 1'b0, 2'd1);
      else if (g != 3)
        dec_chk("R5 esc6 pop", 3'd6, 3'(g), 3'd2, 1'b0, rev_op(3'(g)), 3'd2, 3'd0, 4'd0,
                1'b0, 2'd1);
    end
    dec_chk("R5 esc6 double pop", 3'd6, 3'd3, 3'd1, 1'b0, 6'h03, 3'd0, 3'd1, 4'd0, 1'b0, 2'd2);
    bad_chk("R5/R11 esc6 g3 sub4", 3'd6, 3'd3, 3'd4, 1'b0);
    bad_chk("R5/R11 esc6 g3 sub0", 3'd6, 3'd3, 3'd0, 1'b0);
  endtask

  task automatic t_esc2_reg();
    dec_chk("R6 esc2 ucom", 3'd2, 3'd5, 3'd1, 1'b0, 6'h08, 3'd0, 3'd1, 4'd0, 1'b0, 2'd2);
    bad_chk("R6 esc2 g5 s0", 3'd2, 3'd5, 3'd0, 1'b0);
    bad_chk("R6 esc2 g0 s1", 3'd2, 3'd0, 3'd1, 1'b0);
  endtask

  task automatic t_consts();
    for (int s = 0; s < 7; s++)
      dec_chk("R7 constant", 3'd1, 3'd5, 3'(s), 1'b0, 6'(8'h18 + s), 3'd0, 3'd0, 4'd0,
              1'b1, 2'd0);
    bad_chk("R7 const sub7", 3'd1, 3'd5, 3'd7, 1'b0);
  endtask

  task automatic t_top_move();
    dec_chk("R8 top dec", 3'd1, 3'd6, 3'd6, 1'b0, 6'h26, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0);
    dec_chk("R8 top inc", 3'd1, 3'd6, 3'd7, 1'b0, 6'h27, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0);
    dec_chk("R8 g6 s2",   3'd1, 3'd6, 3'd2, 1'b0, 6'h22, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0);
    dec_chk("R8 g7 s2",   3'd1, 3'd7, 3'd2, 1'b0, 6'h2A, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0);
  endtask

  task automatic t_ctl();
    for (int s = 0; s < 8; s++) begin
      if (s == 2)
        dec_chk("R9 clear", 3'd3, 3'd4, 3'd2, 1'b0, 6'h11, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0);
      else if (s == 3)
        dec_chk("R9 init", 3'd3, 3'd4, 3'd3, 1'b0, 6'h12, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0);
      else if (s == 4 || s == 5)
        dec_chk("R9 nop", 3'd3, 3'd4, 3'(s), 1'b0, 6'h0C, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0);
      else
        bad_chk("R9 illegal sub", 3'd3, 3'd4, 3'(s), 1'b0);
    end
    bad_chk("R9 esc3 g0", 3'd3, 3'd0, 3'd0, 1'b0);
  endtask

  task automatic t_free_stsw();
    dec_chk("R10 free", 3'd5, 3'd0, 3'd5, 1'b0, 6'h13, 3'd5, 3'd0, 4'd0, 1'b0, 2'd0);
    dec_chk("R10 stsw ax", 3'd7, 3'd4, 3'd0, 1'b0, 6'h14, 3'd0, 3'd0, 4'd0, 1'b0, 2'd0);
    bad_chk("R10 esc7 g4 s1", 3'd7, 3'd4, 3'd1, 1'b0);
  endtask

  task automatic t_bad_after_push();
    dec_chk("R11 prior push", 3'd1, 3'd5, 3'd3, 1'b0, 6'h1B, 3'd0, 3'd0, 4'd0, 1'b1, 2'd0);
    bad_chk("R11 mem esc1 g1", 3'd1, 3'd1, 3'd0, 1'b1);
    bad_chk("R11 mem esc7 g1", 3'd7, 3'd1, 3'd0, 1'b1);
  endtask

  task automatic t_loads_stores();
    dec_chk("R12 reg load", 3'd1, 3'd0, 3'd4, 1'b0, 6'h09, 3'd0, 3'd4, 4'd0, 1'b1, 2'd0);
    dec_chk("R12 ld f32", 3'd1, 3'd0, 3'd0, 1'b1, 6'h09, 3'd0, 3'd0, 4'd1, 1'b1, 2'd0);
    dec_chk("R12 ld i32", 3'd3, 3'd0, 3'd0, 1'b1, 6'h09, 3'd0, 3'd0, 4'd2, 1'b1, 2'd0);
    dec_chk("R12 ld f80", 3'd3, 3'd5, 3'd0, 1'b1, 6'h09, 3'd0, 3'd0, 4'd5, 1'b1, 2'd0);
    dec_chk("R12 ld f64", 3'd5, 3'd0, 3'd0, 1'b1, 6'h09, 3'd0, 3'd0, 4'd3, 1'b1, 2'd0);
    dec_chk("R12 ld i16", 3'd7, 3'd0, 3'd0, 1'b1, 6'h09, 3'd0, 3'd0, 4'd4, 1'b1, 2'd0);
    dec_chk("R12 ld bcd", 3'd7, 3'd4, 3'd0, 1'b1, 6'h09, 3'd0, 3'd0, 4'd7, 1'b1, 2'd0);
    dec_chk("R12 ld i64", 3'd7, 3'd5, 3'd0, 1'b1, 6'h09, 3'd0, 3'd0, 4'd6, 1'b1, 2'd0);
    dec_chk("R12 st f64", 3'd5, 3'd2, 3'd0, 1'b1, 6'h0A, 3'd0, 3'd0, 4'd3, 1'b0, 2'd0);
    dec_chk("R12 stp f32", 3'd1, 3'd3, 3'd0, 1'b1, 6'h0A, 3'd0, 3'd0, 4'd1, 1'b0, 2'd1);
    dec_chk("R12 stp f80", 3'd3, 3'd7, 3'd0, 1'b1, 6'h0A, 3'd0, 3'd0, 4'd5, 1'b0, 2'd1);
    dec_chk("R12 stp bcd", 3'd7, 3'd6, 3'd0, 1'b1, 6'h0A, 3'd0, 3'd0, 4'd7, 1'b0, 2'd1);
    dec_chk("R12 stp i64", 3'd7, 3'd7, 3'd0, 1'b1, 6'h0A, 3'd0, 3'd0, 4'd6, 1'b0, 2'd1);
  endtask

  task automatic t_xch_st();
    dec_chk("R13 esc1 stp", 3'd1, 3'd3, 3'd2, 1'b0, 6'h0A, 3'd2, 3'd0, 4'd0, 1'b0, 2'd1);
    dec_chk("R13 esc5 st",  3'd5, 3'd2, 3'd6, 1'b0, 6'h0A, 3'd6, 3'd0, 4'd0, 1'b0, 2'd0);
    dec_chk("R13 esc5 stp", 3'd5, 3'd3, 3'd6, 1'b0, 6'h0A, 3'd6, 3'd0, 4'd0, 1'b0, 2'd1);
    dec_chk("R13 esc7 g2",  3'd7, 3'd2, 3'd1, 1'b0, 6'h0A, 3'd1, 3'd0, 4'd0, 1'b0, 2'd1);
    dec_chk("R13 esc7 g3",  3'd7, 3'd3, 3'd7, 1'b0, 6'h0A, 3'd7, 3'd0, 4'd0, 1'b0, 2'd1);
    for (int e = 1; e < 8; e += 2)
      if (e != 3)
        dec_chk("R13 xch", 3'(e), 3'd1, 3'd5, 1'b0, 6'h0B, 3'd0, 3'd5, 4'd0, 1'b0, 2'd0);
  endtask

  task automatic t_hold();
    dec_chk("R1 before hold", 3'd0, 3'd6, 3'd3, 1'b1, 6'h06, 3'd0, 3'd0, 4'd1, 1'b0, 2'd0);
    @(negedge clk);
    esc_idx = 3'd2; modrm = rm(1'b0, 3'd5, 3'd1); mem_form = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_word("R1 hold idle", 1'b0, 6'h06, 3'd0, 3'd0, 4'd1, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mem_tree();
    t_esc0_reg();
    t_esc4_reg();
    t_esc6_reg();
    t_esc2_reg();
    t_consts();
    t_top_move();
    t_ctl();
    t_free_stsw();
    t_bad_after_push();
    t_loads_stores();
    t_xch_st();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule